// File: doc/BRIEF.md
# Home Site Routing Directory

Each site of a distributed object memory owns routing entries for a fixed slice of the global address space: the addresses for which the site is the home. This block keeps those entries. For each object homed here it records the set of sites that hold a copy and the one site that holds the master copy. The master is the single Original or Exclusive copy. Every message the block emits goes to one destination site.

Incoming messages arrive on a valid/ready stream. An apply is sent to the master and to every clone. A join records that a site now holds a copy. An evict removes a site from the holder set. When the master copy itself is evicted, the block picks a new placement and sends an inject there. A bounced message is one that reached a site which no longer held the master copy; the block redirects it to the current master.

An entry is created on the first join to an address and is never freed. When the table has no free entry, a join for a new address is held back at the input. The output is a valid/ready stream, and each accepted message produces zero or more output messages, one per cycle.

Top module: `home_dir`

## Requirements
- R1: A message whose address modulo NSITES differs from SITE_ID is accepted and dropped. It produces no output and changes no entry.
- R2: Join (in_kind 3) to an unknown address creates an entry with the sender as sole holder and master. Join to a known address adds the sender as a holder. If in_master is 1, the sender also becomes the master and the previous master stays a holder.
- R3: Apply (in_kind 0) to a known address emits one message for each holder, in ascending site order. The master's message has out_kind 0 (forward) and each other holder's has out_kind 1 (update). Every message carries the same address and an origin equal to the sender. An apply to an unknown address emits nothing.
- R4: Evict (in_kind 1) from a site that is not the master removes that site from the holder set and emits nothing.
- R5: Evict from the master removes the sender and elects a target site. It emits one inject (out_kind 2) to that target, and the target becomes a holder and the new master.
- R6: If keep_local is 1 when the master evict is accepted, the target is SITE_ID. Otherwise the target is the next site after the previous round-robin pick, skipping SITE_ID. The round-robin pointer starts at SITE_ID and advances only on picks that are not local.
- R7: Bounce (in_kind 2) to a known address emits one forward (out_kind 0) to the current master, with origin equal to the sender.
- R8: full is 1 exactly when every entry is in use. While full is 1, in_ready is 0 for a homed join to an unknown address; all other messages are still accepted.
- R9: The first output appears in the cycle after acceptance. The output fields hold steady while out_valid is 1 and out_ready is 0. in_ready is 0 while outputs are pending.
- R10: After reset, out_valid is 0, full is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Input message accepted when high with in_valid |
| in_kind | input | 2 | 0 apply, 1 evict, 2 bounce, 3 join |
| in_addr | input | ADDR_W | Global object address |
| in_src | input | log2(NSITES) | Sending site |
| in_master | input | 1 | On join: sender takes the master copy |
| keep_local | input | 1 | On master evict: place the copy at this site |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Downstream takes the output message |
| out_kind | output | 2 | 0 forward, 1 update, 2 inject |
| out_dest | output | log2(NSITES) | Destination site |
| out_addr | output | ADDR_W | Object address |
| out_origin | output | log2(NSITES) | Site that sent the causing message |
| full | output | 1 | No free routing entry |

## Verification
The assertions assume a well-behaved upstream. in_valid stays 0 during reset. A master evict comes only from the site that the table names as master, and the source field names a real site. The stream checks also assume that downstream may stall for any number of cycles. The stimulus comes from a bench-side mirror of the table, so every evict and bounce it sends matches the mirror's current holder sets. It applies back-pressure only through out_ready, and it fills the table only at the end, so the stall on a new join can be observed at the ports.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;
  localparam logic [1:0] IN_APPLY  = 2'd0;
  localparam logic [1:0] IN_EVICT  = 2'd1;
  localparam logic [1:0] IN_BOUNCE = 2'd2;
  localparam logic [1:0] IN_JOIN   = 2'd3;

  localparam logic [1:0] OUT_FWD = 2'd0;
  localparam logic [1:0] OUT_UPD = 2'd1;
  localparam logic [1:0] OUT_INJ = 2'd2;

  typedef enum logic {ST_IDLE, ST_EMIT} dir_state_e;
endpackage

// File: rtl/home_dir_table.sv
module home_dir_table #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8,
  parameter int NSITES  = 4,
  localparam int IW = $clog2(ENTRIES),
  localparam int SW = $clog2(NSITES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [IW-1:0]     hit_idx,
  output logic [NSITES-1:0] rd_holders,
  output logic [SW-1:0]     rd_master,
  output logic              has_free,
  output logic [IW-1:0]     free_idx,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [NSITES-1:0] w_holders,
  input  logic [SW-1:0]     w_master
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [NSITES-1:0]  hold_q [ENTRIES];
  logic [SW-1:0]      mst_q  [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = vld_q[e] && (tag_q[e] == look_addr);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e])  hit_idx  = IW'(e);
      if (!vld_q[e]) free_idx = IW'(e);
    end
  end

  assign hit        = |match;
  assign has_free   = ~&vld_q;
  assign rd_holders = hold_q[hit_idx];
  assign rd_master  = mst_q[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)  vld_q <= '0;
    else if (we) vld_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[widx]  <= w_addr;
      hold_q[widx] <= w_holders;
      mst_q[widx]  <= w_master;
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5
  master_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> w_holders[w_master]);
endmodule

// File: rtl/home_dir_elect.sv
module home_dir_elect #(
  parameter int NSITES  = 4,
  parameter int SITE_ID = 0,
  localparam int SW = $clog2(NSITES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          keep_local,
  output logic [SW-1:0] target
);
  localparam logic [SW-1:0] SELF = SW'(SITE_ID);
  localparam logic [SW-1:0] LAST = SW'(NSITES - 1);

  logic [SW-1:0] rr_q, cand0, cand;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] x);
    return (x == LAST) ? '0 : x + 1'b1;
  endfunction

  assign cand0  = nxt(rr_q);
  assign cand   = (cand0 == SELF) ? nxt(cand0) : cand0;
  assign target = keep_local ? SELF : cand;

  always_ff @(posedge clk) begin
    if (!rst_n)                  rr_q <= SELF;
    else if (step && !keep_local) rr_q <= cand;
  end

  // R6
  rr_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !keep_local) |-> (target != SELF));
endmodule

// File: rtl/home_dir.sv
module home_dir
  import home_dir_pkg::*;
#(
  parameter int NSITES  = 4,
  parameter int SITE_ID = 1,
  parameter int ADDR_W  = 8,
  parameter int ENTRIES = 8,
  localparam int SW = $clog2(NSITES),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SW-1:0]     in_src,
  input  logic              in_master,
  input  logic              keep_local,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [SW-1:0]     out_dest,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SW-1:0]     out_origin,
  output logic              full
);
  localparam logic [ADDR_W-1:0] NS_A   = ADDR_W'(NSITES);
  localparam logic [ADDR_W-1:0] SELF_A = ADDR_W'(SITE_ID);
  localparam logic [NSITES-1:0] ONE    = NSITES'(1);

  dir_state_e        st_q;
  logic [NSITES-1:0] pend_q, nx_pend, src_bit, tgt_bit;
  logic              inj_q, nx_inj, step;
  logic [SW-1:0]     mst_q, cur, tgt;
  logic [ADDR_W-1:0] addr_q;
  logic [SW-1:0]     org_q;
  logic              homed, acc;

  logic              hit, has_free, tab_we;
  logic [IW-1:0]     hit_idx, free_idx, w_idx;
  logic [NSITES-1:0] rd_holders, w_hold;
  logic [SW-1:0]     rd_master, w_mst;

  home_dir_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .NSITES(NSITES)) u_table (
    .clk, .rst_n, .look_addr(in_addr), .hit, .hit_idx, .rd_holders, .rd_master,
    .has_free, .free_idx, .we(tab_we), .widx(w_idx), .w_addr(in_addr),
    .w_holders(w_hold), .w_master(w_mst)
  );

  home_dir_elect #(.NSITES(NSITES), .SITE_ID(SITE_ID)) u_elect (
    .clk, .rst_n, .step, .keep_local, .target(tgt)
  );

  assign homed    = (in_addr % NS_A) == SELF_A;
  assign full     = !has_free;
  assign in_ready = (st_q == ST_IDLE) &&
                    !(homed && in_kind == IN_JOIN && !hit && !has_free);
  assign acc      = in_valid && in_ready;
  assign src_bit  = ONE << in_src;
  assign tgt_bit  = ONE << tgt;

  always_comb begin
    tab_we  = 1'b0;
    w_idx   = hit_idx;
    w_hold  = rd_holders;
    w_mst   = rd_master;
    nx_pend = '0;
    nx_inj  = 1'b0;
    step    = 1'b0;
    if (acc && homed) begin
      case (in_kind)
        IN_APPLY:  if (hit) nx_pend = rd_holders;
        IN_BOUNCE: if (hit) nx_pend = ONE << rd_master;
        IN_EVICT: if (hit) begin
          tab_we = 1'b1;
          if (in_src == rd_master) begin
            step    = 1'b1;
            w_hold  = (rd_holders & ~src_bit) | tgt_bit;
            w_mst   = tgt;
            nx_pend = tgt_bit;
            nx_inj  = 1'b1;
          end else begin
            w_hold = rd_holders & ~src_bit;
          end
        end
        default: begin
          tab_we = 1'b1;
          if (hit) begin
            w_hold = rd_holders | src_bit;
            if (in_master) w_mst = in_src;
          end else begin
            w_idx  = free_idx;
            w_hold = src_bit;
            w_mst  = in_src;
          end
        end
      endcase
    end
  end

  always_comb begin
    cur = '0;
    for (int s = NSITES - 1; s >= 0; s--)
      if (pend_q[s]) cur = SW'(s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      inj_q  <= 1'b0;
      mst_q  <= '0;
      addr_q <= '0;
      org_q  <= '0;
    end else if (acc) begin
      pend_q <= nx_pend;
      inj_q  <= nx_inj;
      mst_q  <= rd_master;
      addr_q <= in_addr;
      org_q  <= in_src;
      st_q   <= (|nx_pend) ? ST_EMIT : ST_IDLE;
    end else if (st_q == ST_EMIT && out_ready) begin
      pend_q <= pend_q & ~(ONE << cur);
      if (pend_q == (ONE << cur)) st_q <= ST_IDLE;
    end
  end

  assign out_valid  = (st_q == ST_EMIT);
  assign out_dest   = cur;
  assign out_kind   = inj_q ? OUT_INJ : ((cur == mst_q) ? OUT_FWD : OUT_UPD);
  assign out_addr   = addr_q;
  assign out_origin = org_q;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) &&
      $stable(out_kind) && $stable(out_addr) && $stable(out_origin)));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9
  first_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R8
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
endmodule

// File: tb/home_dir_test.sv
module home_dir_test;
  localparam int N   = 4;
  localparam int SID = 1;
  localparam int ENT = 4;
  localparam int AW  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_master = 1'b0, keep_local = 1'b0;
  logic [1:0] in_kind = '0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0] in_src = '0;
  logic out_valid, out_ready = 1'b1, full;
  logic [1:0] out_kind, out_dest, out_origin;
  logic [AW-1:0] out_addr;

  home_dir #(.NSITES(N), .SITE_ID(SID), .ADDR_W(AW), .ENTRIES(ENT)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_kind, .in_addr, .in_src, .in_master,
    .keep_local, .out_valid, .out_ready, .out_kind, .out_dest, .out_addr,
    .out_origin, .full
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit pres [64];
  int hold [64];
  int mst  [64];
  int nent = 0;
  int rr = SID;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic msg(input int kind, input int addr, input int src, input bit mf,
                     input bit kl, input bit bp, input string tag);
    int n = 0;
    int ek[4];
    int ed[4];
    int t;
    bit homed = (addr % N) == SID;
    bit stall = homed && kind == 3 && !pres[addr] && nent == ENT;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind[1:0]; in_addr = addr[AW-1:0];
    in_src = src[1:0]; in_master = mf; keep_local = kl;
    if (bp) out_ready = 1'b0;
    #2;
    if (stall) begin
      chk(in_ready == 1'b0, "R8", "in_ready on full", int'(in_ready), 0);
      chk(full == 1'b1, "R8", "full", int'(full), 1);
      @(negedge clk); #2;
      chk(!in_ready && !out_valid, "R8", "stall held", int'(in_ready), 0);
      in_valid = 1'b0; out_ready = 1'b1;
      return;
    end
    if (homed) begin
      case (kind)
        0: if (pres[addr])
             for (int s = 0; s < N; s++)
               if (hold[addr][s]) begin
                 ek[n] = (s == mst[addr]) ? 0 : 1; ed[n] = s; n++;
               end
        2: if (pres[addr]) begin ek[0] = 0; ed[0] = mst[addr]; n = 1; end
        1: if (pres[addr]) begin
             if (src == mst[addr]) begin
               if (kl) t = SID;
               else begin
                 t = (rr + 1) % N;
                 if (t == SID) t = (t + 1) % N;
                 rr = t;
               end
               hold[addr] = (hold[addr] & ~(1 << src)) | (1 << t);
               mst[addr] = t;
               ek[0] = 2; ed[0] = t; n = 1;
             end else hold[addr] = hold[addr] & ~(1 << src);
           end
        default: if (pres[addr]) begin
             hold[addr] = hold[addr] | (1 << src);
             if (mf) mst[addr] = src;
           end else begin
             pres[addr] = 1'b1; hold[addr] = 1 << src; mst[addr] = src; nent++;
           end
      endcase
    end
    chk(in_ready == 1'b1, tag, "in_ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    for (int i = 0; i < n; i++) begin
      chk(out_valid == 1'b1, tag, "out_valid", int'(out_valid), 1);
      chk(int'(out_kind) * 4 + int'(out_dest) == ek[i] * 4 + ed[i], tag, "kind*4+dest",
          int'(out_kind) * 4 + int'(out_dest), ek[i] * 4 + ed[i]);
      chk(int'(out_addr) * 4 + int'(out_origin) == addr * 4 + src, tag, "addr*4+origin",
          int'(out_addr) * 4 + int'(out_origin), addr * 4 + src);
      if (bp && i == 0) begin
        @(negedge clk); #2;
        chk(out_valid && int'(out_kind) * 4 + int'(out_dest) == ek[0] * 4 + ed[0],
            "R9", "held under stall", int'(out_kind) * 4 + int'(out_dest), ek[0] * 4 + ed[0]);
        chk(!in_ready, "R9", "in_ready while busy", int'(in_ready), 0);
        out_ready = 1'b1;
      end
      @(negedge clk); #2;
    end
    out_ready = 1'b1;
    chk(out_valid == 1'b0, tag, "no further output", int'(out_valid), 0);
    chk(full == (nent == ENT), "R8", "full level", int'(full), int'(nent == ENT));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!out_valid && !full && in_ready, "R10", "reset state",
        int'({out_valid, full, in_ready}), 1);
    rst_n = 1'b1;

    // R1: every kind to every foreign address up to 15
    for (int a = 0; a < 16; a++)
      if (a % N != SID)
        for (int k = 0; k < 4; k++) msg(k, a, a % N, 1'b1, 1'b0, 1'b0, "R1");

    msg(0, 5, 0, 0, 0, 0, "R3");
    msg(1, 21, 0, 0, 0, 0, "R4");

    // R2: create three objects, join every other site as a clone
    for (int j = 0; j < 3; j++) begin
      msg(3, 1 + 4 * j, j, 0, 0, 0, "R2");
      for (int s = 0; s < N; s++)
        if (s != j) msg(3, 1 + 4 * j, s, 0, 0, 0, "R2");
    end

    // R3 sweep with back-pressure on some
    for (int j = 0; j < 3; j++)
      for (int s = 0; s < N; s++) msg(0, 1 + 4 * j, s, 0, 0, s == 2, "R3");

    for (int j = 0; j < 3; j++) msg(2, 1 + 4 * j, 3, 0, 0, 0, "R7");

    msg(3, 5, 3, 1, 0, 0, "R2");
    msg(0, 5, 0, 0, 0, 1, "R2");
    msg(2, 5, 1, 0, 0, 0, "R7");

    msg(1, 9, 0, 0, 0, 0, "R4");
    msg(1, 9, 3, 0, 0, 0, "R4");
    msg(0, 9, 1, 0, 0, 0, "R4");

    // R6: repeated master evicts, one local pick
    for (int i = 0; i < 6; i++) begin
      msg(1, 1, mst[1], 0, i == 3, i == 1, i == 3 ? "R6" : "R5");
      msg(0, 1, 0, 0, 0, 0, "R6");
    end

    msg(3, 13, 3, 0, 0, 0, "R2");
    msg(1, 13, 3, 0, 0, 0, "R5");
    msg(0, 13, 2, 0, 0, 0, "R5");

    msg(3, 17, 0, 0, 0, 0, "R8");
    msg(0, 13, 1, 0, 0, 0, "R8");
    msg(3, 2, 0, 0, 0, 0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule